// File: doc/BRIEF.md
# Orbit Marker Selector with Programmable Delay and Fanout

This block produces the orbit-start marker (BC0) and the bunch-clock enable for a group of trigger-primitive boards. The marker comes from one of three sources, chosen by a mode register. It can be decoded from broadcast command words that arrive with a strobe. It can be taken from an external marker input driven by an upstream distribution board. It can also come from a free-running internal orbit counter, which allows stand-alone running.

The chosen marker is first registered. It then passes through a delay line whose tap is set by software, from 0 to 63 bunch ticks. The result is copied into a bank of identical output registers, one per destination board.

The block is clocked by a reference clock that is a multiple of the bunch rate. A divider produces `bx_ce`, and all marker logic advances only on that enable. A simple write port sets the mode, the delay and the broadcast code that stands for BC0. A write to the mode or the delay clears every marker still in flight, so a reconfiguration cannot emit a stray or doubled pulse.

Top module: `orbit_mark_fanout`

## Requirements
- R1: While `rst_n` is low, every `bc0_out` bit is 0. Reset leaves mode = broadcast decode, delay = 0 and BC0 code = 0x01.
- R2: `bx_ce` is high for one clock out of every CLK_DIV clocks (default 2). A bunch tick is a rising clock edge at which `bx_ce` is high.
- R3: In mode 0, `ttc_strobe` high with `ttc_cmd` equal to the BC0 code at tick T drives all outputs high during the single tick period that follows tick T+1+D, where D is the delay.
- R4: Register address 2 (all 8 data bits) holds the BC0 code. A command that differs from it, or a command without `ttc_strobe`, produces no marker.
- R5: In mode 1, a rising edge of `ext_bc0` seen at tick T gives one marker at T+1+D. The input held high for several ticks still gives exactly one marker.
- R6: In mode 2, an internal counter started at reset fires at every tick k with k a multiple of ORBIT_LEN (default 3564; ticks are counted from 1 after reset). Each firing gives a marker at k+1+D.
- R7: Register address 1, data bits [5:0], sets D from 0 to 63.
- R8: A write to address 0 or 1 clears all output registers at that clock edge, together with every marker held in the pipeline. A marker that was in flight before the write never appears.
- R9: The sources that are not selected have no effect. Mode 3 (address 0, data bits [1:0] = 3) keeps every output at 0.
- R10: All NUM_OUT (default 18) outputs always carry the same value. A marker lasts exactly one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe, one clock |
| cfg_addr | input | 2 | 0 mode, 1 delay, 2 BC0 code |
| cfg_wdata | input | 8 | Register write data |
| ttc_strobe | input | 1 | Broadcast command valid, sampled at ticks |
| ttc_cmd | input | 8 | Broadcast command word |
| ext_bc0 | input | 1 | Marker from upstream board, sampled at ticks |
| bx_ce | output | 1 | Bunch-clock enable |
| bc0_out | output | 18 | Identical delayed markers |

## Verification
The bench goes after the latency at both ends of the delay range. An off-by-one in the tap mux would shift the marker by a tick at D=0 or lose it at D=63. It holds the external input high for several ticks: a design without edge detection would emit a train of markers instead of one. It rewrites the delay while a marker sits in the line: a design without the flush would let that marker out late or twice. It runs two full orbits on the internal counter while it watches that the unselected sources and mode 3 stay silent. A wrong modulus would put the orbit markers on the wrong ticks, and a leaky multiplexer would let stray markers through.

// File: rtl/omf_pkg.sv
package omf_pkg;
  typedef enum logic [1:0] {
    SRC_TTC = 2'd0,
    SRC_EXT = 2'd1,
    SRC_INT = 2'd2,
    SRC_OFF = 2'd3
  } src_e;

  localparam logic [1:0] ADDR_MODE  = 2'd0;
  localparam logic [1:0] ADDR_DELAY = 2'd1;
  localparam logic [1:0] ADDR_CODE  = 2'd2;
endpackage

// File: rtl/omf_src_sel.sv
module omf_src_sel
  import omf_pkg::*;
#(
  parameter int CMD_W     = 8,
  parameter int ORBIT_LEN = 3564
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             flush,
  input  src_e             mode,
  input  logic [CMD_W-1:0] code,
  input  logic             ttc_strobe,
  input  logic [CMD_W-1:0] ttc_cmd,
  input  logic             ext_bc0,
  output logic             sel_o
);
  localparam int CNT_W = $clog2(ORBIT_LEN);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(ORBIT_LEN - 1);

  logic [CNT_W-1:0] orbit_q, orbit_nxt;
  logic             ext_prev_q, ext_prev_nxt;
  logic             sel_q, sel_nxt;
  logic             raw_ttc, raw_ext, raw_int, raw;

  // free-running orbit counter, independent of mode and flush
  always_comb begin
    orbit_nxt = orbit_q;
    if (ce) orbit_nxt = (orbit_q == LAST) ? '0 : orbit_q + 1'b1;
  end

  assign raw_ttc = ttc_strobe && (ttc_cmd == code);
  assign raw_ext = ext_bc0 && !ext_prev_q;
  assign raw_int = (orbit_q == LAST);

  always_comb begin
    unique case (mode)
      SRC_TTC: raw = raw_ttc;
      SRC_EXT: raw = raw_ext;
      SRC_INT: raw = raw_int;
      default: raw = 1'b0;
    endcase
  end

  always_comb begin
    ext_prev_nxt = ext_prev_q;
    sel_nxt      = sel_q;
    if (ce) ext_prev_nxt = ext_bc0;
    if (flush)   sel_nxt = 1'b0;
    else if (ce) sel_nxt = raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      orbit_q    <= '0;
      ext_prev_q <= 1'b0;
      sel_q      <= 1'b0;
    end else begin
      orbit_q    <= orbit_nxt;
      ext_prev_q <= ext_prev_nxt;
      sel_q      <= sel_nxt;
    end
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/omf_delay_line.sv
module omf_delay_line #(
  parameter int MAX_DLY = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ce,
  input  logic                       flush,
  input  logic                       din,
  input  logic [$clog2(MAX_DLY)-1:0] dly,
  output logic                       dout
);
  localparam int STAGES = MAX_DLY - 1;

  logic [STAGES-1:0]  line_q;
  logic [MAX_DLY-1:0] taps;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic stage_in, stage_nxt;
    if (i == 0) begin : g_head
      assign stage_in = din;
    end else begin : g_body
      assign stage_in = line_q[i-1];
    end

    always_comb begin
      stage_nxt = line_q[i];
      if (flush)   stage_nxt = 1'b0;
      else if (ce) stage_nxt = stage_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) line_q[i] <= 1'b0;
      else        line_q[i] <= stage_nxt;
    end
  end

  // tap 0 is the undelayed input, tap n is stage n-1
  assign taps = {line_q, din};
  assign dout = taps[dly];
endmodule

// File: rtl/omf_fanout.sv
module omf_fanout #(
  parameter int NUM_OUT = 18
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               flush,
  input  logic               din,
  output logic [NUM_OUT-1:0] q
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic nxt;
    always_comb begin
      nxt = q[j];
      if (flush)   nxt = 1'b0;
      else if (ce) nxt = din;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[j] <= 1'b0;
      else        q[j] <= nxt;
    end
  end
endmodule

// File: rtl/orbit_mark_fanout.sv
module orbit_mark_fanout
  import omf_pkg::*;
#(
  parameter int              NUM_OUT   = 18,
  parameter int              CMD_W     = 8,
  parameter int              MAX_DLY   = 64,
  parameter int              ORBIT_LEN = 3564,
  parameter int              CLK_DIV   = 2,
  parameter logic [CMD_W-1:0] DEF_CODE = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [1:0]         cfg_addr,
  input  logic [CMD_W-1:0]   cfg_wdata,
  input  logic               ttc_strobe,
  input  logic [CMD_W-1:0]   ttc_cmd,
  input  logic               ext_bc0,
  output logic               bx_ce,
  output logic [NUM_OUT-1:0] bc0_out
);
  localparam int DLY_W = $clog2(MAX_DLY);

  src_e             mode_q, mode_nxt;
  logic [DLY_W-1:0] dly_q, dly_nxt;
  logic [CMD_W-1:0] code_q, code_nxt;
  logic             flush, sel, tapped;

  // bunch-clock enable
  if (CLK_DIV == 1) begin : g_ce_full
    assign bx_ce = 1'b1;
  end else begin : g_ce_div
    localparam int PH_W = $clog2(CLK_DIV);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
    logic [PH_W-1:0] ph_q, ph_nxt;
    always_comb ph_nxt = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_nxt;
    end
    assign bx_ce = (ph_q == PH_LAST);
  end

  // configuration registers
  always_comb begin
    mode_nxt = mode_q;
    dly_nxt  = dly_q;
    code_nxt = code_q;
    if (cfg_we) begin
      unique case (cfg_addr)
        ADDR_MODE:  mode_nxt = src_e'(cfg_wdata[1:0]);
        ADDR_DELAY: dly_nxt  = cfg_wdata[DLY_W-1:0];
        ADDR_CODE:  code_nxt = cfg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SRC_TTC;
      dly_q  <= '0;
      code_q <= DEF_CODE;
    end else begin
      mode_q <= mode_nxt;
      dly_q  <= dly_nxt;
      code_q <= code_nxt;
    end
  end

  assign flush = cfg_we && (cfg_addr == ADDR_MODE || cfg_addr == ADDR_DELAY);

  omf_src_sel #(.CMD_W(CMD_W), .ORBIT_LEN(ORBIT_LEN)) u_src (
    .clk(clk), .rst_n(rst_n), .ce(bx_ce), .flush(flush), .mode(mode_q),
    .code(code_q), .ttc_strobe(ttc_strobe), .ttc_cmd(ttc_cmd),
    .ext_bc0(ext_bc0), .sel_o(sel)
  );

  omf_delay_line #(.MAX_DLY(MAX_DLY)) u_dly (
    .clk(clk), .rst_n(rst_n), .ce(bx_ce), .flush(flush), .din(sel),
    .dly(dly_q), .dout(tapped)
  );

  omf_fanout #(.NUM_OUT(NUM_OUT)) u_fan (
    .clk(clk), .rst_n(rst_n), .ce(bx_ce), .flush(flush), .din(tapped),
    .q(bc0_out)
  );
endmodule

// File: rtl/omf_chk.sv
module omf_chk #(
  parameter int NUM_OUT = 18,
  parameter int CMD_W   = 8,
  parameter int CLK_DIV = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_we,
  input logic [1:0]         cfg_addr,
  input logic [CMD_W-1:0]   cfg_wdata,
  input logic               bx_ce,
  input logic [NUM_OUT-1:0] bc0_out
);
  logic [1:0] mode_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_sh <= 2'd0;
    else if (cfg_we && cfg_addr == 2'd0) mode_sh <= cfg_wdata[1:0];
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) reset_quiet_chk: assert (bc0_out == '0);
  end

  if (CLK_DIV == 2) begin : g_div2
    // R2
    ce_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bx_ce |=> !bx_ce);
    // R2
    ce_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bx_ce |=> bx_ce);
  end

  // R10
  same_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc0_out == '0) || (bc0_out == '1));

  // R10
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(bx_ce) && !$past(cfg_we)) |-> $stable(bc0_out));

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_addr == 2'd0 || cfg_addr == 2'd1)) |=> (bc0_out == '0));

  // R9
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sh == 2'd3 && $past(mode_sh) == 2'd3) |-> (bc0_out == '0));
endmodule

bind orbit_mark_fanout omf_chk #(.NUM_OUT(NUM_OUT), .CMD_W(CMD_W), .CLK_DIV(CLK_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .bx_ce(bx_ce), .bc0_out(bc0_out)
);

// File: tb/sim_orbit_mark_fanout.sv
`timescale 1ns/1ps
module sim_orbit_mark_fanout;
  localparam int NOUT = 18;
  localparam int L    = 3564;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [7:0]       cfg_wdata = '0;
  logic             ttc_strobe = 1'b0;
  logic [7:0]       ttc_cmd = '0;
  logic             ext_bc0 = 1'b0;
  logic             bx_ce;
  logic [NOUT-1:0]  bc0_out;

  orbit_mark_fanout u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ttc_strobe(ttc_strobe), .ttc_cmd(ttc_cmd),
    .ext_bc0(ext_bc0), .bx_ce(bx_ce), .bc0_out(bc0_out)
  );

  always #4 clk = ~clk;

  typedef struct { int t; string req; } exp_t;
  exp_t exp_q[$];

  int errors = 0;
  int checks = 0;
  int tick = 0;
  bit ce_seen = 0;
  bit done = 0;

  int mode_m = 0;
  int dly_m = 0;
  int code_m = 1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d tick=%0d", req, act, expv, tick);
    end
  endtask

  // monitor: one comparison after each bunch tick
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (ce_seen) begin
        bit expd;
        string rq;
        tick++;
        while (exp_q.size() > 0 && exp_q[0].t < tick) void'(exp_q.pop_front());
        expd = (exp_q.size() > 0 && exp_q[0].t == tick);
        rq = expd ? exp_q[0].req : "R9";
        check(bc0_out == '0 || bc0_out == '1, "R10", int'(bc0_out[0]), int'(bc0_out[NOUT-1]));
        check(bc0_out[0] == expd, rq, int'(bc0_out[0]), int'(expd));
        if (expd) void'(exp_q.pop_front());
      end
      ce_seen = bx_ce;
    end
  end

  task automatic wait_ce();
    do begin
      @(negedge clk); #1;
    end while (!bx_ce);
  endtask

  task automatic wait_ticks(input int n);
    repeat (n) wait_ce();
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); #1;
    cfg_we = 1'b0;
    if (a == 2'd0) begin mode_m = int'(d[1:0]); exp_q.delete(); end
    if (a == 2'd1) begin dly_m  = int'(d[5:0]); exp_q.delete(); end
    if (a == 2'd2) code_m = int'(d);
  endtask

  task automatic ttc_send(input logic [7:0] cmd, input bit stb, input string req);
    wait_ce();
    ttc_cmd = cmd; ttc_strobe = stb;
    if (mode_m == 0 && stb && int'(cmd) == code_m)
      exp_q.push_back('{t: tick + 2 + dly_m, req: req});
    wait_ce();
    ttc_strobe = 1'b0; ttc_cmd = '0;
  endtask

  task automatic ext_pulse(input int hold, input string req);
    wait_ce();
    ext_bc0 = 1'b1;
    if (mode_m == 1) exp_q.push_back('{t: tick + 2 + dly_m, req: req});
    wait_ticks(hold);
    ext_bc0 = 1'b0;
    wait_ce();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int ones;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(bc0_out == '0, "R1", int'(bc0_out[0]), 0);
    rst_n = 1'b1;
    // R2 enable rate
    ones = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #2;
      if (bx_ce) ones++;
    end
    check(ones == 4, "R2", ones, 4);

    // R1 R3 default code and zero delay
    ttc_send(8'h01, 1'b1, "R3");
    wait_ticks(4);
    ttc_send(8'h01, 1'b0, "R4");
    ttc_send(8'h02, 1'b1, "R4");
    wait_ticks(3);
    cfg_write(2'd2, 8'h5A);
    ttc_send(8'h01, 1'b1, "R4");
    ttc_send(8'h5A, 1'b1, "R4");
    wait_ticks(4);

    // R7 delay extremes and back-to-back markers
    cfg_write(2'd1, 8'd63);
    ttc_send(8'h5A, 1'b1, "R7");
    wait_ticks(70);
    cfg_write(2'd1, 8'd17);
    ttc_send(8'h5A, 1'b1, "R7");
    wait_ticks(2);
    ttc_send(8'h5A, 1'b1, "R7");
    wait_ticks(25);

    // R5 external source, single and held
    cfg_write(2'd0, 8'd1);
    ext_pulse(1, "R5");
    wait_ticks(3);
    ext_pulse(4, "R5");
    ttc_send(8'h5A, 1'b1, "R9");
    wait_ticks(25);

    // R8 flush of in-flight marker on delay and mode writes
    cfg_write(2'd1, 8'd20);
    ext_pulse(1, "R8");
    wait_ticks(5);
    cfg_write(2'd1, 8'd20);
    wait_ticks(30);
    ext_pulse(1, "R8");
    wait_ticks(5);
    cfg_write(2'd0, 8'd1);
    wait_ticks(30);

    // R6 internal orbit counter
    cfg_write(2'd1, 8'd3);
    cfg_write(2'd0, 8'd2);
    begin
      int k;
      k = ((tick / L) + 1) * L;
      if (k < tick + 3) k += L;
      exp_q.push_back('{t: k + 1 + dly_m, req: "R6"});
      exp_q.push_back('{t: k + L + 1 + dly_m, req: "R6"});
      while (tick < k + L + 1 + dly_m + 3) wait_ce();
    end

    // R9 unselected sources and mode 3
    cfg_write(2'd0, 8'd1);
    ttc_send(8'h5A, 1'b1, "R9");
    wait_ticks(L + 10);
    cfg_write(2'd0, 8'd3);
    ext_pulse(1, "R9");
    ttc_send(8'h5A, 1'b1, "R9");
    wait_ticks(30);

    check(exp_q.size() == 0, "R3", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule